// File: doc/BRIEF.md
# Stereo PDM Microphone Capture Front-End

This block receives a single pulse-density-modulated data line shared by two microphones, A (left) and B (right), and produces the microphone clock that drives them. The line is sampled once in each half of every microphone-clock period. The slot that follows the rising clock edge and the slot that follows the falling edge are split into two separate 1-bit streams, each with a one-cycle valid strobe. The strobes are meant to feed a downstream decimation filter.

Each channel has its own enable and its own bit-inversion control. A swap control exchanges which clock edge feeds which channel. A skew value postpones the sampling instant by a whole number of block-clock cycles. `clk_i` runs at twice the source-clock rate, so each of its cycles stands for one half-cycle of the source clock. The microphone clock is divided down from `clk_i`. All controls are captured only while capture is stopped. The capture run uses the values present in the cycle in which `run_i` is first seen high.

Top module: `pdm_pair_capture`

## Requirements
- R1: While stopped, `mclk_o` is 0. When `run_i` is first sampled high, `mclk_o` is 1 for MCLK_HALF cycles and then 0 for MCLK_HALF cycles, repeating, starting in the cycle after that clock edge.
- R2: With `swap_i`=0, the rising-edge slot goes to channel A and the falling-edge slot goes to channel B. With `swap_i`=1 the two slots are exchanged. The rising-edge event is the first cycle of the high phase, and the falling-edge event is the first cycle of the low phase.
- R3: With skew s (0..15), the data bit of a slot is the value of `pdm_i` during the cycle s cycles after that slot's edge event. The valid strobe and bit appear in the following cycle.
- R4: When a channel's inversion control is 1, every bit delivered on that channel is the complement of the sampled line value.
- R5: A channel whose enable is 0 never raises its valid strobe.
- R6: Each channel raises its strobe at most once per microphone-clock period, for exactly one cycle. The A and B strobes are never high in the same cycle.
- R7: Enable, inversion, swap and skew inputs are taken only while stopped. Changes made while running have no effect on the delivered bits, strobes or slot mapping.
- R8: After `run_i` is sampled low, no strobe appears from the following cycle on. Slots whose delayed sampling cycle falls after the stop are dropped.
- R9: Out of reset, `mclk_o`, both strobes and both data bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, one cycle per source half-cycle |
| rst_ni | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Capture run control |
| en_a_i | input | 1 | Channel A enable |
| en_b_i | input | 1 | Channel B enable |
| inv_a_i | input | 1 | Channel A bit inversion |
| inv_b_i | input | 1 | Channel B bit inversion |
| swap_i | input | 1 | Exchange edge-to-channel mapping |
| skew_i | input | SKEW_W | Sampling delay in clk_i cycles |
| pdm_i | input | 1 | Shared microphone data line |
| mclk_o | output | 1 | Generated microphone clock |
| bit_a_o | output | 1 | Channel A PDM bit |
| vld_a_o | output | 1 | Channel A bit strobe |
| bit_b_o | output | 1 | Channel B PDM bit |
| vld_b_o | output | 1 | Channel B bit strobe |

## Verification
Two things can fall in the same cycle: the capture of the control settings and the start of a run. The bench provokes this by presenting a configuration in the very cycle `run_i` rises. It then rewrites every control in mid-run, flipping inversion, swap, skew and one enable. The scoreboard is filled only from the settings present at the start, so any bit, strobe timing or slot mapping that follows the late values is judged a mismatch. A stop placed in the same window as pending delayed slots checks that those slots are dropped and not delivered late.

// File: rtl/pdmc_pkg.sv
package pdmc_pkg;

   // per-channel settings captured at run start
   typedef struct packed {
      logic en;
      logic inv;
   } chan_cfg_t;

   // slot index inside the event vector
   localparam int SLOT_RISE = 0;
   localparam int SLOT_FALL = 1;
   localparam int N_SLOT    = 2;

endpackage

// File: rtl/pdmc_clkgen.sv
module pdmc_clkgen #(
   parameter int MCLK_HALF = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_q_i,
   output logic mclk_o,
   output logic [pdmc_pkg::N_SLOT-1:0] ev_o
);
   localparam int PERIOD = 2 * MCLK_HALF;
   localparam int CNT_W  = (PERIOD > 1) ? $clog2(PERIOD) : 1;
   localparam logic [CNT_W-1:0] HALF_C = CNT_W'(MCLK_HALF);
   localparam logic [CNT_W-1:0] LAST_C = CNT_W'(PERIOD - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni || !run_q_i) begin
         cnt_q <= '0;
      end else if (cnt_q == LAST_C) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign mclk_o = run_q_i && (cnt_q < HALF_C);
   always_comb begin
      ev_o = '0;
      ev_o[pdmc_pkg::SLOT_RISE] = run_q_i && (cnt_q == '0);
      ev_o[pdmc_pkg::SLOT_FALL] = run_q_i && (cnt_q == HALF_C);
   end
endmodule

// File: rtl/pdmc_skew_line.sv
module pdmc_skew_line #(
   parameter int SKEW_W = 4,
   parameter int LANES  = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clr_i,
   input  logic [LANES-1:0]  ev_i,
   input  logic [SKEW_W-1:0] sel_i,
   output logic [LANES-1:0]  tap_o
);
   localparam int DEPTH = 1 << SKEW_W;

   // stage k holds the events of k+1 cycles ago
   logic [DEPTH-2:0][LANES-1:0] dly_q;

   generate
      if (DEPTH == 2) begin : g_one
         always_ff @(posedge clk_i) begin
            if (!rst_ni || clr_i) dly_q <= '0;
            else                  dly_q <= ev_i;
         end
      end else begin : g_many
         always_ff @(posedge clk_i) begin
            if (!rst_ni || clr_i) dly_q <= '0;
            else                  dly_q <= {dly_q[DEPTH-3:0], ev_i};
         end
      end
   endgenerate

   always_comb begin
      if (sel_i == '0) tap_o = ev_i;
      else             tap_o = dly_q[sel_i - 1'b1];
   end
endmodule

// File: rtl/pdmc_chan.sv
module pdmc_chan (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 run_q_i,
   input  logic                 hit_i,
   input  logic                 data_i,
   input  pdmc_pkg::chan_cfg_t  cfg_i,
   output logic                 bit_o,
   output logic                 vld_o
);
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         bit_o <= 1'b0;
         vld_o <= 1'b0;
      end else begin
         vld_o <= run_q_i && hit_i && cfg_i.en;
         if (run_q_i && hit_i && cfg_i.en) bit_o <= data_i ^ cfg_i.inv;
      end
   end
endmodule

// File: rtl/pdm_pair_capture.sv
module pdm_pair_capture #(
   parameter int MCLK_HALF = 4,
   parameter int SKEW_W    = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              run_i,
   input  logic              en_a_i,
   input  logic              en_b_i,
   input  logic              inv_a_i,
   input  logic              inv_b_i,
   input  logic              swap_i,
   input  logic [SKEW_W-1:0] skew_i,
   input  logic              pdm_i,
   output logic              mclk_o,
   output logic              bit_a_o,
   output logic              vld_a_o,
   output logic              bit_b_o,
   output logic              vld_b_o
);
   import pdmc_pkg::*;

   generate
      if (MCLK_HALF < 1) begin : g_bad_half
         $error("MCLK_HALF must be at least 1");
      end
      if (SKEW_W < 1 || SKEW_W > 8) begin : g_bad_skew
         $error("SKEW_W must lie in 1..8");
      end
   endgenerate

   logic              run_q;
   chan_cfg_t         cfg_q [N_SLOT];
   logic              swap_q;
   logic [SKEW_W-1:0] skew_q;

   // settings follow the inputs only while stopped
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         run_q     <= 1'b0;
         cfg_q[0]  <= '0;
         cfg_q[1]  <= '0;
         swap_q    <= 1'b0;
         skew_q    <= '0;
      end else begin
         run_q <= run_i;
         if (!run_q) begin
            cfg_q[0] <= '{en: en_a_i, inv: inv_a_i};
            cfg_q[1] <= '{en: en_b_i, inv: inv_b_i};
            swap_q   <= swap_i;
            skew_q   <= skew_i;
         end
      end
   end

   logic [N_SLOT-1:0] ev, tap;

   pdmc_clkgen #(.MCLK_HALF(MCLK_HALF)) clkgen_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_q_i (run_q),
      .mclk_o  (mclk_o),
      .ev_o    (ev)
   );

   pdmc_skew_line #(.SKEW_W(SKEW_W), .LANES(N_SLOT)) skew_i_line (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (!run_q),
      .ev_i   (ev),
      .sel_i  (skew_q),
      .tap_o  (tap)
   );

   logic [N_SLOT-1:0] ch_bit, ch_vld;

   generate
      for (genvar c = 0; c < N_SLOT; c++) begin : g_ch
         logic hit;
         // channel c normally takes slot c; swap takes the other one
         assign hit = swap_q ? tap[N_SLOT-1-c] : tap[c];
         pdmc_chan chan_i (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .run_q_i (run_q),
            .hit_i   (hit),
            .data_i  (pdm_i),
            .cfg_i   (cfg_q[c]),
            .bit_o   (ch_bit[c]),
            .vld_o   (ch_vld[c])
         );
      end
   endgenerate

   assign bit_a_o = ch_bit[0];
   assign vld_a_o = ch_vld[0];
   assign bit_b_o = ch_bit[1];
   assign vld_b_o = ch_vld[1];
endmodule

// File: rtl/pdm_pair_capture_chk.sv
module pdm_pair_capture_chk #(
   parameter int CFG_W = 8
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             run_q,
   input logic             mclk_o,
   input logic             vld_a_o,
   input logic             vld_b_o,
   input logic             en_a_q,
   input logic             en_b_q,
   input logic [CFG_W-1:0] cfg_all
);
   a_r1_mclk_low_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_q |-> !mclk_o);

   a_r5_a_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_a_q |-> !vld_a_o);

   a_r5_b_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_b_q |-> !vld_b_o);

   a_r6_not_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(vld_a_o && vld_b_o));

   a_r6_a_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_a_o |=> !vld_a_o);

   a_r6_b_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_b_o |=> !vld_b_o);

   a_r7_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_q && $past(run_q)) |-> $stable(cfg_all));

   a_r8_quiet_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(run_q) |-> (!vld_a_o && !vld_b_o));
endmodule

bind pdm_pair_capture pdm_pair_capture_chk #(.CFG_W(5 + SKEW_W)) chk_i (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .run_q   (run_q),
   .mclk_o  (mclk_o),
   .vld_a_o (vld_a_o),
   .vld_b_o (vld_b_o),
   .en_a_q  (cfg_q[0].en),
   .en_b_q  (cfg_q[1].en),
   .cfg_all ({cfg_q[0], cfg_q[1], swap_q, skew_q})
);

// File: tb/pdm_pair_capture_tb.sv
module pdm_pair_capture_tb_top;
   localparam int H  = 4;
   localparam int SW = 4;

   logic clk = 1'b0, rst_ni = 1'b0, run_i = 1'b0;
   logic en_a_i = 1'b0, en_b_i = 1'b0, inv_a_i = 1'b0, inv_b_i = 1'b0, swap_i = 1'b0;
   logic [SW-1:0] skew_i = '0;
   logic pdm_i = 1'b0;
   logic mclk_o, bit_a_o, vld_a_o, bit_b_o, vld_b_o;

   pdm_pair_capture #(.MCLK_HALF(H), .SKEW_W(SW)) dut_i (
      .clk_i(clk), .rst_ni(rst_ni), .run_i(run_i),
      .en_a_i(en_a_i), .en_b_i(en_b_i), .inv_a_i(inv_a_i), .inv_b_i(inv_b_i),
      .swap_i(swap_i), .skew_i(skew_i), .pdm_i(pdm_i),
      .mclk_o(mclk_o), .bit_a_o(bit_a_o), .vld_a_o(vld_a_o),
      .bit_b_o(bit_b_o), .vld_b_o(vld_b_o)
   );

   always #2 clk = ~clk;

   typedef struct { int cyc; logic b; string tag; } item_t;
   item_t qa[$], qb[$];
   int cyc = 0, n_cmp = 0, n_bad = 0;
   int run_lo = 1, run_hi = 0;
   bit mon_on = 1'b0, done = 1'b0;

   function automatic logic fpat(int n);
      logic [31:0] v;
      v = n * 32'h9E37_79B1;
      return v[13] ^ v[27];
   endfunction

   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) pdm_i <= fpat(cyc);

   task automatic check(string tag, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
      end
   endtask

   task automatic mon_lane(ref item_t q[$], input logic vld, input logic b, input string nm);
      if (q.size() > 0 && q[0].cyc < cyc) begin
         check({q[0].tag, " missing strobe ", nm}, 0, 1);
         void'(q.pop_front());
      end
      if (vld) begin
         if (q.size() == 0 || q[0].cyc != cyc) begin
            check({"R5/R8 unexpected strobe ", nm}, 1, 0);
         end else begin
            item_t it;
            it = q.pop_front();
            check({it.tag, " bit ", nm}, int'(b), int'(it.b));
         end
      end
   endtask

   // monitor: scoreboard pops and microphone-clock shape (R1)
   always @(negedge clk) begin
      if (mon_on) begin
         logic exp_m;
         exp_m = (cyc >= run_lo && cyc <= run_hi) ? (((cyc - run_lo) % (2*H)) < H) : 1'b0;
         check("R1 mclk", int'(mclk_o), int'(exp_m));
         check("R6 A and B strobes together", int'(vld_a_o && vld_b_o), 0);
         mon_lane(qa, vld_a_o, bit_a_o, "A");
         mon_lane(qb, vld_b_o, bit_b_o, "B");
      end
   end

   // driver: program, predict, run for len cycles, optionally rewrite controls mid-run
   task automatic run_case(string tag, logic ea, logic eb, logic ia, logic ib,
                           logic sw, int s, int len, bit chg);
      int m, p;
      @(negedge clk);
      en_a_i = ea; en_b_i = eb; inv_a_i = ia; inv_b_i = ib; swap_i = sw;
      skew_i = SW'(s);
      run_i = 1'b1;
      m = cyc;
      p = m + len;
      for (int ev = m + 1; ev <= p; ev += 2*H) begin
         for (int k = 0; k < 2; k++) begin
            int e;
            bit to_a;
            item_t it;
            e = ev + k*H;
            to_a = (k == 0) ^ sw;
            if (e + s <= p && (to_a ? ea : eb)) begin
               it.cyc = e + s + 1;
               it.b   = fpat(e + s) ^ (to_a ? ia : ib);
               it.tag = tag;
               if (to_a) qa.push_back(it); else qb.push_back(it);
            end
         end
      end
      run_lo = m + 1;
      run_hi = p;
      while (cyc < p) begin
         @(negedge clk);
         if (chg && cyc == m + len/2) begin
            // R7: these must not take effect
            en_a_i = ~ea; inv_a_i = ~ia; inv_b_i = ~ib; swap_i = ~sw;
            skew_i = SW'(s + 7);
         end
      end
      run_i = 1'b0;
      repeat (24) @(negedge clk);
      check({tag, " leftover A"}, qa.size(), 0);
      check({tag, " leftover B"}, qb.size(), 0);
      qa.delete();
      qb.delete();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_ni = 1'b1;
      @(negedge clk);
      check("R9 reset mclk", int'(mclk_o), 0);
      check("R9 reset vld_a", int'(vld_a_o), 0);
      check("R9 reset vld_b", int'(vld_b_o), 0);
      check("R9 reset bits", int'(bit_a_o | bit_b_o), 0);
      mon_on = 1'b1;
      run_case("R2 R3 base",          1, 1, 0, 0, 0,  0, 64, 0);
      run_case("R3 R4 skew5 invA",    1, 1, 1, 0, 0,  5, 64, 0);
      run_case("R2 R3 R4 swap skew15", 1, 1, 0, 1, 1, 15, 80, 0);
      run_case("R5 A disabled",       0, 1, 0, 0, 0,  3, 48, 0);
      run_case("R5 B disabled swap",  1, 0, 1, 1, 1,  1, 48, 0);
      run_case("R7 mid-run rewrite",  1, 1, 0, 0, 0,  2, 96, 1);
      run_case("R8 short stop skew14", 1, 1, 0, 0, 0, 14, 21, 0);
      run_case("R6 odd skew inv both", 1, 1, 1, 1, 0,  7, 56, 0);
      mon_on = 1'b0;
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule